// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block holds the control and status registers of an ECC memory controller. Software reaches nine 32-bit registers through a word-addressed port: enable, delay, fault status, video configuration, two fault address words, diagnostic, and two event counters. The ECC logic reports a fault through a strobed input. That input loads the fault status and both fault address words, and it raises an interrupt. Software clears the interrupt by writing the fault status register.

A parameter picks one of three chip variants. The variant decides which enable bits are writable, whether identity bits appear in the enable register, and which enable bits survive a soft reset. Variant 0 also has a four-byte diagnostic window with byte access. There are two resets. The power-on reset loads every register. The soft reset leaves chosen enable bits in place and reloads the rest.

Top module: `eccregs`

## Requirements
- R1: On variants 1 and 2, enable bits [31:28] read back as the variant number and bits [27:24] as the VERSION parameter. On variant 0 these eight bits read as zero. After power-on reset the enable register holds exactly these identity bits.
- R2: A write to the enable register (word 0) stores data & 0x103 on variant 0. On variants 1 and 2 it stores the identity bits OR'ed with data & 0xBFF.
- R3: A write to the delay register (word 1) stores data & 0x7FFFFFFF, so bit 31 always reads zero.
- R4: A bus write to the fault status register (word 2) stores the written value. The interrupt is low from the next clock edge on.
- R5: A fault strobe loads fault status (word 2), fault address 0 (word 4) and fault address 1 (word 5), and the interrupt is high from the next edge. If a bus write to word 2 falls in the same cycle, the fault wins.
- R6: When a fault arrives and the held fault status has any of bits [3:0] set, the stored status also gets bit 16 (multiple errors). Otherwise the status is stored exactly as given.
- R7: On soft reset, variant 0 keeps only enable bit 8. Variants 1 and 2 keep enable bits [31:24], [9:2] and 11. Every other enable bit is cleared.
- R8: Either reset loads delay = 0x20 and fault address 0 = 0x07C00000. It clears fault status, video configuration (word 3), fault address 1, diagnostic (word 6), both event counters and the interrupt.
- R9: Bus writes to words 4 and 5 are ignored.
- R10: An access whose byte address has bits [1:0] nonzero, or whose word index is above 8, reads zero, and a write to it changes nothing.
- R11: Event counter 0 (word 7) and event counter 1 (word 8) are separate 32-bit storage locations.
- R12: On variant 0, a diagnostic write stores a byte at diag_addr, and diag_rdata returns the byte at diag_addr. These bytes are cleared only by power-on reset. On other variants, diagnostic writes are ignored and reads return zero.
- R13: Video configuration, diagnostic and both event counters store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous soft reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| diag_wr | input | 1 | Diagnostic byte write strobe |
| diag_addr | input | 2 | Diagnostic byte address |
| diag_wdata | input | 8 | Diagnostic write byte |
| diag_rdata | output | 8 | Diagnostic read byte |
| flt_valid | input | 1 | Fault report strobe |
| flt_status | input | 32 | Fault status word |
| flt_addr0 | input | 32 | Fault address word 0 |
| flt_addr1 | input | 32 | Fault address word 1 |
| irq | output | 1 | Fault interrupt |

## Verification
The assertions run on every cycle and check several properties:
- the identity bits in the enable register,
- delay bit 31 reading zero,
- the interrupt rising after each fault strobe and falling after a status write,
- the multiple-error bit appearing when a fault lands on an unserviced error,
- both fault address words staying stable when there is no fault,
- misaligned reads returning zero.

Only the bench scenarios can show the rest, because each needs a chosen sequence of writes:
- the write masks per variant,
- which enable bits the soft reset keeps,
- the reset values,
- the separate event counter 1,
- the fault winning a same-cycle collision,
- the diagnostic window on one variant and its absence on another.

// File: rtl/eccregs.sv
module eccregs #(
  parameter int unsigned VARIANT = 1,
  parameter int unsigned VERSION = 3,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              diag_wr,
  input  logic [1:0]        diag_addr,
  input  logic [7:0]        diag_wdata,
  output logic [7:0]        diag_rdata,
  input  logic              flt_valid,
  input  logic [31:0]       flt_status,
  input  logic [31:0]       flt_addr0,
  input  logic [31:0]       flt_addr1,
  output logic              irq
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [31:0] IDENT = (VARIANT == 0) ? 32'h0 :
    (((32'(VARIANT) & 32'hF) << 28) | ((32'(VERSION) & 32'hF) << 24));
  localparam logic [31:0] WMASK = (VARIANT == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  localparam logic [31:0] KEEP  = (VARIANT == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  localparam logic [31:0] MULTI = 32'h0001_0000;

  localparam logic [IDX_W-1:0] I_EN   = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_DLY  = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_STAT = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_VID  = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_FA0  = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_FA1  = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_DIAG = IDX_W'(6);
  localparam logic [IDX_W-1:0] I_CNT0 = IDX_W'(7);
  localparam logic [IDX_W-1:0] I_CNT1 = IDX_W'(8);

  logic [31:0] en_q, dly_q, stat_q, vid_q, fa0_q, fa1_q, dg_q, cnt0_q, cnt1_q;
  logic        irq_q;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic             any_rst;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign idx     = bus_addr[ADDR_W-1:2];
  assign any_rst = !por_n || !rst_n;
  assign irq     = irq_q;

  function automatic logic wr_hit(input logic [IDX_W-1:0] k);
    return bus_wr && aligned && (idx == k);
  endfunction

  always_ff @(posedge clk) begin
    if (any_rst) begin
      en_q   <= !por_n ? IDENT : (en_q & KEEP);
      dly_q  <= 32'h0000_0020;
      stat_q <= '0;
      vid_q  <= '0;
      fa0_q  <= 32'h07C0_0000;
      fa1_q  <= '0;
      dg_q   <= '0;
      cnt0_q <= '0;
      cnt1_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_hit(I_EN))   en_q   <= IDENT | (bus_wdata & WMASK);
      if (wr_hit(I_DLY))  dly_q  <= bus_wdata & 32'h7FFF_FFFF;
      if (wr_hit(I_VID))  vid_q  <= bus_wdata;
      if (wr_hit(I_DIAG)) dg_q   <= bus_wdata;
      if (wr_hit(I_CNT0)) cnt0_q <= bus_wdata;
      if (wr_hit(I_CNT1)) cnt1_q <= bus_wdata;
      if (flt_valid) begin
        stat_q <= flt_status | ((|stat_q[3:0]) ? MULTI : 32'h0);
        fa0_q  <= flt_addr0;
        fa1_q  <= flt_addr1;
        irq_q  <= 1'b1;
      end else if (wr_hit(I_STAT)) begin
        stat_q <= bus_wdata;
        irq_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        I_EN:    bus_rdata = en_q;
        I_DLY:   bus_rdata = dly_q;
        I_STAT:  bus_rdata = stat_q;
        I_VID:   bus_rdata = vid_q;
        I_FA0:   bus_rdata = fa0_q;
        I_FA1:   bus_rdata = fa1_q;
        I_DIAG:  bus_rdata = dg_q;
        I_CNT0:  bus_rdata = cnt0_q;
        I_CNT1:  bus_rdata = cnt1_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  generate
    if (VARIANT == 0) begin : g_diag
      logic [7:0] bytes_q [4];
      always_ff @(posedge clk) begin
        if (!por_n) begin
          for (int i = 0; i < 4; i++) bytes_q[i] <= '0;
        end else if (diag_wr) begin
          bytes_q[diag_addr] <= diag_wdata;
        end
      end
      assign diag_rdata = bytes_q[diag_addr];
    end else begin : g_nodiag
      logic unused_diag;
      assign unused_diag = ^{diag_wr, diag_addr, diag_wdata};
      assign diag_rdata  = 8'h00;
    end
  endgenerate

  a_r1_identity: assert property (@(posedge clk) disable iff (!por_n)
    (VARIANT != 0) |-> (en_q[31:24] == IDENT[31:24]));

  a_r3_delay_msb: assert property (@(posedge clk) disable iff (any_rst)
    (aligned && idx == I_DLY) |-> !bus_rdata[31]);

  a_r4_status_clears_irq: assert property (@(posedge clk) disable iff (any_rst)
    (wr_hit(I_STAT) && !flt_valid) |=> (!irq && stat_q == $past(bus_wdata)));

  a_r5_fault_raises_irq: assert property (@(posedge clk) disable iff (any_rst)
    flt_valid |=> (irq && stat_q[15:0] == $past(flt_status[15:0]) && fa0_q == $past(flt_addr0)));

  a_r6_multi_error: assert property (@(posedge clk) disable iff (any_rst)
    (flt_valid && (|stat_q[3:0])) |=> stat_q[16]);

  a_r9_fault_addr_hold: assert property (@(posedge clk) disable iff (any_rst)
    !flt_valid |=> ($stable(fa0_q) && $stable(fa1_q)));

  a_r10_misaligned_zero: assert property (@(posedge clk) disable iff (any_rst)
    !aligned |-> (bus_rdata == 32'h0));
endmodule

// File: tb/eccregs_bench.sv
module eccregs_bench;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b1;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        diag_wr = 1'b0;
  logic [1:0]  diag_addr = '0;
  logic [7:0]  diag_wdata = '0;
  logic        flt_valid = 1'b0;
  logic [31:0] flt_status = '0, flt_addr0 = '0, flt_addr1 = '0;
  logic [31:0] rd1, rd0;
  logic [7:0]  dg1, dg0;
  logic        irq1, irq0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eccregs #(.VARIANT(1), .VERSION(3), .ADDR_W(6)) u_eccregs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .diag_wr(diag_wr), .diag_addr(diag_addr),
    .diag_wdata(diag_wdata), .diag_rdata(dg1), .flt_valid(flt_valid),
    .flt_status(flt_status), .flt_addr0(flt_addr0), .flt_addr1(flt_addr1), .irq(irq1));

  eccregs #(.VARIANT(0), .VERSION(3), .ADDR_W(6)) u_eccregs_v0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .diag_wr(diag_wr), .diag_addr(diag_addr),
    .diag_wdata(diag_wdata), .diag_rdata(dg0), .flt_valid(flt_valid),
    .flt_status(flt_status), .flt_addr0(flt_addr0), .flt_addr1(flt_addr1), .irq(irq0));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a);
    bus_addr = a;
    #1;
  endtask

  task automatic fault(input logic [31:0] s, input logic [31:0] a0, input logic [31:0] a1);
    @(negedge clk);
    flt_valid = 1'b1; flt_status = s; flt_addr0 = a0; flt_addr1 = a1;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic t_por;
    rd(0);  chk("R1 v1 enable identity", rd1, 32'h1300_0000);
            chk("R1 v0 enable zero", rd0, 32'h0);
    rd(4);  chk("R8 delay reset", rd1, 32'h20);
    rd(16); chk("R8 fault addr0 reset", rd1, 32'h07C0_0000);
    rd(8);  chk("R8 status reset", rd1, 32'h0);
    chk("R8 irq reset", {31'b0, irq1}, 32'h0);
  endtask

  task automatic t_masks;
    wr(0, 32'hFFFF_FFFF);
    rd(0);  chk("R2 v1 enable mask", rd1, 32'h1300_0BFF);
            chk("R2 v0 enable mask", rd0, 32'h0000_0103);
    wr(4, 32'hFFFF_FFFF);
    rd(4);  chk("R3 delay mask", rd1, 32'h7FFF_FFFF);
  endtask

  task automatic t_plain;
    wr(12, 32'hDEAD_BEEF);
    wr(24, 32'hC0FF_EE5A);
    wr(28, 32'h0000_0011);
    wr(32, 32'h0000_0022);
    rd(12); chk("R13 video rw", rd1, 32'hDEAD_BEEF);
    rd(24); chk("R13 diagnostic rw", rd1, 32'hC0FF_EE5A);
    rd(28); chk("R11 counter0 separate", rd1, 32'h11);
    rd(32); chk("R11 counter1 separate", rd1, 32'h22);
  endtask

  task automatic t_soft_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(0);  chk("R7 v1 enable kept bits", rd1, 32'h1300_0BFC);
            chk("R7 v0 enable kept bit8", rd0, 32'h0000_0100);
    rd(4);  chk("R8 delay after soft reset", rd1, 32'h20);
    rd(12); chk("R8 video cleared", rd1, 32'h0);
    rd(24); chk("R8 diagnostic cleared", rd1, 32'h0);
    rd(28); chk("R8 counter0 cleared", rd1, 32'h0);
    rd(32); chk("R8 counter1 cleared", rd1, 32'h0);
    rd(16); chk("R8 fault addr0 after soft reset", rd1, 32'h07C0_0000);
  endtask

  task automatic t_fault;
    fault(32'h9, 32'h1234_5678, 32'h9ABC_DEF0);
    chk("R5 irq raised", {31'b0, irq1}, 32'h1);
    rd(8);  chk("R5 status loaded", rd1, 32'h9);
    rd(16); chk("R5 fault addr0", rd1, 32'h1234_5678);
    rd(20); chk("R5 fault addr1", rd1, 32'h9ABC_DEF0);
    fault(32'h1, 32'h1, 32'h2);
    rd(8);  chk("R6 multiple-error set", rd1, 32'h0001_0001);
    wr(8, 32'h0);
    chk("R4 irq cleared by write", {31'b0, irq1}, 32'h0);
    rd(8);  chk("R4 status written", rd1, 32'h0);
    fault(32'h20, 32'h3, 32'h4);
    fault(32'h4, 32'h5, 32'h6);
    rd(8);  chk("R6 no multiple-error without prior error", rd1, 32'h4);
  endtask

  task automatic t_collide;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8; bus_wdata = 32'h0;
    flt_valid = 1'b1; flt_status = 32'h8; flt_addr0 = 32'hA0A0_A0A0; flt_addr1 = 32'h0B0B_0B0B;
    @(negedge clk);
    bus_wr = 1'b0; flt_valid = 1'b0;
    chk("R5 fault wins collision irq", {31'b0, irq1}, 32'h1);
    rd(8);  chk("R5 fault wins collision status", rd1, 32'h0001_0008);
    wr(8, 32'h0);
  endtask

  task automatic t_readonly;
    wr(16, 32'hFFFF_FFFF);
    wr(20, 32'hFFFF_FFFF);
    rd(16); chk("R9 fault addr0 read-only", rd1, 32'hA0A0_A0A0);
    rd(20); chk("R9 fault addr1 read-only", rd1, 32'h0B0B_0B0B);
  endtask

  task automatic t_decode;
    wr(36, 32'h55);
    rd(36); chk("R10 unmapped index reads zero", rd1, 32'h0);
    rd(60); chk("R10 high index reads zero", rd1, 32'h0);
    wr(13, 32'h1234);
    rd(12); chk("R10 misaligned write ignored", rd1, 32'h0);
    wr(12, 32'h77);
    rd(13); chk("R10 misaligned read zero", rd1, 32'h0);
  endtask

  task automatic t_diag;
    @(negedge clk); diag_wr = 1'b1; diag_addr = 2; diag_wdata = 8'hAB;
    @(negedge clk); diag_addr = 0; diag_wdata = 8'h5C;
    @(negedge clk); diag_wr = 1'b0;
    diag_addr = 2; #1;
    chk("R12 v0 diag byte2", {24'b0, dg0}, 32'hAB);
    chk("R12 v1 diag absent", {24'b0, dg1}, 32'h0);
    diag_addr = 0; #1;
    chk("R12 v0 diag byte0", {24'b0, dg0}, 32'h5C);
    diag_addr = 1; #1;
    chk("R12 v0 diag byte1 untouched", {24'b0, dg0}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_por();
    t_masks();
    t_plain();
    t_soft_reset();
    t_fault();
    t_collide();
    t_readonly();
    t_decode();
    t_diag();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule